// File: doc/BRIEF.md
# Nonvolatile Memory Status Register Controller

This block holds the status register of a serial nonvolatile memory. It receives command strobes that have already been decoded: enable writes, disable writes, read status, write status and start a memory write. With the write-status strobe comes a data byte. The block keeps the two block-protect bits, the write-enable latch and the busy flag. A status read captures a snapshot of the status byte. The block decides whether a status write or a memory write is accepted. An accepted write starts a busy window that stands in for the programming time.

The busy window lasts a parameterised number of clock cycles. When a status write is accepted, its new protect bits show in the status byte on the very next cycle, while programming is still under way. The write-enable latch clears when the window closes. The enable and disable commands act whatever the protect bits hold. Every command that would change state is dropped while the block is busy. Status reads are still served during that time.

Top module: `nvm_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00: protect bits 0, write-enable latch 0, busy 0.
- R2: The status byte is arranged as {4'b0000, protect[1:0], enable latch, busy}: bit 0 is busy, bit 1 is the enable latch, bits 3:2 are the protect bits, and bits 7:4 always read 0.
- R3: When idle, the enable strobe sets the enable latch and the disable strobe clears it, from the next cycle on, whatever the protect bits hold.
- R4: A write-status strobe accepted while idle with the latch at 1 loads din[3:2] into the protect bits, which read back on the next cycle while busy is already 1.
- R5: A write-status or memory-write strobe with the enable latch at 0 is ignored. Busy stays 0 and the protect bits do not change.
- R6: An accepted write holds busy at 1 for exactly PROG_CYCLES cycles. prog_done is 1 during the last of them. On the cycle after that, busy and the enable latch both read 0.
- R7: While busy is 1, the enable, disable, write-status and memory-write strobes have no effect on the protect bits, the enable latch or the length of the busy window.
- R8: A read-status strobe, busy or not, gives rd_valid=1 on the next cycle, with rd_data equal to the status byte in the cycle of the strobe.
- R9: mem_grant is 1 in the same cycle as a memory-write strobe exactly when that strobe is accepted (idle, latch 1, no write-status strobe present).
- R10: Among strobes arriving in the same idle cycle, the order of precedence is write-status, then memory-write, then enable, then disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Enable-writes strobe |
| cmd_wrdis | input | 1 | Disable-writes strobe |
| cmd_rdsr | input | 1 | Read-status strobe |
| cmd_wrsr | input | 1 | Write-status strobe |
| cmd_memwr | input | 1 | Memory-write start strobe |
| din | input | 8 | Data byte for a status write (bits 3:2 used) |
| status | output | 8 | Live status byte |
| rd_data | output | 8 | Status snapshot taken by the last read strobe |
| rd_valid | output | 1 | rd_data updated in the previous cycle |
| mem_grant | output | 1 | Memory-write strobe accepted this cycle |
| prog_done | output | 1 | Last cycle of the busy window |

## Verification
mem_grant is combinational, so it is due in the cycle of the strobe. Every registered result is due one edge after its strobe: the protect bits, the enable latch, busy going high, rd_valid and rd_data. Busy falls PROG_CYCLES edges after it rises, and prog_done is due in the last busy cycle. The bench applies strobes just after a falling edge. It checks mem_grant and prog_done 1 ns later, lets one rising edge pass, and compares every registered output at the next falling edge with a reference model stepped once per rising edge.

// File: rtl/nvm_status_ctrl.sv
module nvm_status_ctrl #(
  parameter int PROG_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wren,
  input  logic       cmd_wrdis,
  input  logic       cmd_rdsr,
  input  logic       cmd_wrsr,
  input  logic       cmd_memwr,
  input  logic [7:0] din,
  output logic [7:0] status,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       mem_grant,
  output logic       prog_done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  logic [1:0]    prot;
  logic          wel;
  logic          busy;
  logic [CW-1:0] left;

  wire take_sr = ~busy & wel & cmd_wrsr;
  wire take_mw = ~busy & wel & cmd_memwr & ~cmd_wrsr;

  assign mem_grant = take_mw;
  assign prog_done = busy & (left == '0);
  assign status    = {4'b0000, prot, wel, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot     <= '0;
      wel      <= 1'b0;
      busy     <= 1'b0;
      left     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= cmd_rdsr;
      if (cmd_rdsr) rd_data <= status;
      if (take_sr || take_mw) begin
        busy <= 1'b1;
        left <= LOAD;
        if (take_sr) prot <= din[3:2];
      end else if (prog_done) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else if (busy) begin
        left <= left - 1'b1;
      end else if (cmd_wren) begin
        wel <= 1'b1;
      end else if (cmd_wrdis) begin
        wel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nvm_status_ctrl_chk.sv
module nvm_status_ctrl_chk #(
  parameter int PROG_CYCLES = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_rdsr,
  input logic [7:0] status,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       mem_grant,
  input logic       prog_done
);
  int unsigned blen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         blen <= 0;
    else if (status[0]) blen <= blen + 1;
    else                blen <= 0;
  end

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) status[7:4] == 4'b0000);
  // R5
  start_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[0]) |-> $past(status[1]));
  // R6
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(status[0]) |-> blen == PROG_CYCLES);
  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n) prog_done |=> !status[0] && !status[1]);
  // R7
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) status[0] |=> $stable(status[3:2]));
  // R8
  read_snap_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_rdsr |=> rd_valid && rd_data == $past(status));
  // R9
  grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_grant |=> status[0]);
endmodule

bind nvm_status_ctrl nvm_status_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_rdsr(cmd_rdsr), .status(status),
  .rd_data(rd_data), .rd_valid(rd_valid), .mem_grant(mem_grant), .prog_done(prog_done)
);

// File: tb/nvm_status_ctrl_test.sv
`timescale 1ns/1ps
module nvm_status_ctrl_test;
  localparam int P = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wren = 0, wrdis = 0, rdsr = 0, wrsr = 0, memwr = 0;
  logic [7:0] din = '0;
  logic [7:0] status, rd_data;
  logic rd_valid, mem_grant, prog_done;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [1:0] m_prot; logic m_wel; int m_left;
  logic [7:0] m_rd; logic m_rdv;

  always #10 clk = ~clk;

  nvm_status_ctrl #(.PROG_CYCLES(P)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wren(wren), .cmd_wrdis(wrdis), .cmd_rdsr(rdsr),
    .cmd_wrsr(wrsr), .cmd_memwr(memwr), .din(din), .status(status), .rd_data(rd_data),
    .rd_valid(rd_valid), .mem_grant(mem_grant), .prog_done(prog_done));

  function automatic logic [7:0] exp_status();
    return {4'b0000, m_prot, m_wel, m_left > 0};
  endfunction

  function automatic logic exp_grant();
    return m_left == 0 && m_wel && memwr && !wrsr;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step_model();
    m_rdv = rdsr;
    if (rdsr) m_rd = exp_status();
    if (m_left == 0) begin
      if (wrsr && m_wel) begin m_prot = din[3:2]; m_left = P; end
      else if (memwr && m_wel) m_left = P;
      else if (wren) m_wel = 1;
      else if (wrdis) m_wel = 0;
    end else begin
      if (m_left == 1) m_wel = 0;
      m_left--;
    end
  endtask

  task automatic cyc(logic a, logic b, logic c, logic d, logic e, logic [7:0] v);
    {wren, wrdis, rdsr, wrsr, memwr} = {a, b, c, d, e};
    din = v;
    #1;
    chk("R9 grant", mem_grant, exp_grant());
    chk("R6 done", prog_done, m_left == 1);
    @(posedge clk);
    step_model();
    @(negedge clk);
    chk("R3/R4/R6 status", status, exp_status());
    chk("R8 valid", rd_valid, m_rdv);
    if (m_rdv) chk("R8 data", rd_data, m_rd);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    int busy_len;
    seed = 17;
    void'($urandom(seed));
    m_prot = 0; m_wel = 0; m_left = 0; m_rd = 0; m_rdv = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R5: write-status with latch clear is ignored
    cyc(0, 0, 0, 1, 0, 8'h0C);
    chk("R5 ignored wrsr", status, 8'h00);
    cyc(0, 0, 0, 0, 1, 8'h00);
    chk("R5 ignored memwr", status[0], 1'b0);
    // R3
    cyc(1, 0, 0, 0, 0, 8'h00);
    chk("R3 wren", status[1], 1'b1);
    // R4 / R2: new protect bits visible at once while busy
    cyc(0, 0, 0, 1, 0, 8'h0C);
    chk("R2 layout busy", status, 8'h0F);
    chk("R4 prot early", status[3:2], 2'b11);
    // R8 read while busy
    cyc(0, 0, 1, 0, 0, 8'h00);
    chk("R8 read busy", rd_data, 8'h0F);
    // R7 strobes while busy
    cyc(0, 1, 0, 1, 1, 8'h00);
    chk("R7 busy ignore", status, 8'h0F);
    busy_len = 3;
    while (status[0]) begin cyc(0, 0, 0, 0, 0, 8'h00); if (status[0]) busy_len++; end
    chk("R6 busy length", busy_len, P);
    chk("R6 latch cleared", status, 8'h0C);
    // R3 under protection: enable/disable still act
    cyc(1, 0, 0, 0, 0, 8'h00);
    cyc(0, 1, 0, 0, 0, 8'h00);
    chk("R3 wrdis protected", status, 8'h0C);
    // R10 precedence
    cyc(1, 0, 0, 0, 0, 8'h00);
    cyc(1, 1, 0, 1, 1, 8'h04);
    chk("R10 wrsr first", status, 8'h07);
    idle(P);
    cyc(1, 1, 0, 0, 0, 8'h00);
    chk("R10 wren over wrdis", status[1], 1'b1);
    cyc(0, 0, 0, 0, 1, 8'h00);
    chk("R9 memwr start", status, 8'h07);
    idle(P);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] s;
      s = 5'($urandom) & 5'($urandom);
      cyc(s[0], s[1], s[2], s[3], s[4], 8'($urandom));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule